// File: doc/BRIEF.md
# Multiplexed RAM Pulse Counter

This block keeps one pulse count per channel for a large set of channels whose pulse outputs all share one clock. Every channel changes level at the same instant and then holds that level for a fixed hold interval. It does not use one counter per channel. The counts live in one synchronous single-port RAM word per channel, and a single incrementer is shared across all of them.

A strobe marks the start of each hold interval. On the strobe, the block latches the whole channel vector. It then sweeps the channels in ascending index order, and each channel takes three clocks: read its word, add the latched bit, write the word back. A channel that stays high for several intervals gains one count per interval.

A clear command zeroes every word in a sweep of the same length. That sweep also runs by itself after reset. A host can read any channel's count, but only while no sweep is running or starting.

Top module: `mux_pulse_counter`

## Requirements
- R1: After reset the block runs a clearing sweep (busy_o high) and then every channel reads back 0; busy_o is low while reset is asserted.
- R2: A win_i pulse taken while idle latches chan_i in that cycle. At the end of the sweep, each channel's count has risen by 1 if its latched bit was 1 and is unchanged if it was 0. Changes on chan_i after the strobe cycle do not affect that sweep.
- R3: Counts are CNT_W bits wide and wrap modulo 2^CNT_W, so a channel at 2^CNT_W-1 goes to 0.
- R4: Every sweep keeps busy_o high for exactly 3*N_CH consecutive cycles, starting the cycle after it is started. Words are handled in ascending index order, and each word is written back two cycles after it was read, at the same address.
- R5: A win_i pulse that arrives while busy_o is high is ignored: no count changes and the sweep does not get longer.
- R6: A clr_i pulse while idle starts a clearing sweep at once, and all counts read 0 afterwards. If clr_i and win_i come in the same idle cycle, the clear wins and that interval is not counted. A clr_i pulse during a counting sweep is held; the clearing sweep starts one idle cycle after the counting sweep ends.
- R7: rd_gnt_o is high in a cycle when rd_req_i is high, the block is idle, and no sweep starts in that cycle. In the next cycle rd_vld_o is high and rd_data_o holds the count of the channel rd_ch_i named at grant time. For an index of N_CH or more, rd_data_o is 0.
- R8: A channel held high across K consecutive intervals gains K counts, modulo 2^CNT_W.
- R9: rd_gnt_o is never high while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_i | input | N_CH | Channel pulse levels, one bit per channel |
| win_i | input | 1 | Single-cycle strobe marking the start of a hold interval |
| clr_i | input | 1 | Single-cycle command to zero all counts |
| rd_req_i | input | 1 | Host read request |
| rd_ch_i | input | CH_W | Channel index to read |
| rd_gnt_o | output | 1 | Host read accepted this cycle |
| rd_vld_o | output | 1 | rd_data_o is valid |
| rd_data_o | output | CNT_W | Count of the granted channel |
| busy_o | output | 1 | A sweep is in progress |

## Verification
A wrong sweep index or a corrupted latched vector puts a count on the wrong channel. That shows up at the very next host read after the sweep, which is at most 3*N_CH+2 cycles after the strobe. A stuck or misordered state machine shows up as a busy_o pulse of the wrong length within one sweep. A lost pending clear shows up as non-zero counts read straight after the sweep that should have followed. Incrementer width faults show only at the wrap point, so the bench uses a narrow counter and drives every channel through several full wraps.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_MOD,
    ST_WR
  } sweep_st_e;
endpackage

// File: rtl/mpc_ram.sv
module mpc_ram #(
  parameter int DEPTH = 72,
  parameter int W     = 16,
  parameter int AW    = 7
) (
  input  logic          clk_i,
  input  logic          re_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/mpc_sweep_ctrl.sv
module mpc_sweep_ctrl
  import mpc_pkg::*;
#(
  parameter int N_CH  = 72,
  parameter int CNT_W = 16,
  parameter int CH_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  chan_i,
  input  logic             win_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] ram_rdata_i,
  output logic             ram_re_o,
  output logic             ram_we_o,
  output logic [CH_W-1:0]  ram_addr_o,
  output logic [CNT_W-1:0] ram_wdata_o,
  output logic             busy_o,
  output logic             free_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(N_CH - 1);

  sweep_st_e        state_q;
  logic [CH_W-1:0]  idx_q;
  logic [N_CH-1:0]  snap_q;
  logic             clr_mode_q;
  logic             clr_pend_q;
  logic [CNT_W-1:0] wdata_q;

  logic idle, start_clr, start_cnt;

  assign idle      = (state_q == ST_IDLE);
  assign start_clr = idle && (clr_pend_q || clr_i);
  assign start_cnt = idle && !start_clr && win_i;
  assign free_o    = idle && !start_clr && !win_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      snap_q     <= '0;
      clr_mode_q <= 1'b0;
      clr_pend_q <= 1'b1;  // clearing sweep right after reset
      wdata_q    <= '0;
    end else begin
      if (clr_i && !idle) clr_pend_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_clr) begin
            clr_mode_q <= 1'b1;
            clr_pend_q <= 1'b0;
            idx_q      <= '0;
            state_q    <= ST_RD;
          end else if (start_cnt) begin
            snap_q     <= chan_i;
            clr_mode_q <= 1'b0;
            idx_q      <= '0;
            state_q    <= ST_RD;
          end
        end
        ST_RD:  state_q <= ST_MOD;
        ST_MOD: begin
          wdata_q <= clr_mode_q ? '0 : ram_rdata_i + CNT_W'(snap_q[idx_q]);
          state_q <= ST_WR;
        end
        ST_WR: begin
          if (idx_q == LAST) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + CH_W'(1);
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ram_re_o    = (state_q == ST_RD);
  assign ram_we_o    = (state_q == ST_WR);
  assign ram_addr_o  = idx_q;
  assign ram_wdata_o = wdata_q;
  assign busy_o      = !idle;
endmodule

// File: rtl/mpc_host_port.sv
module mpc_host_port #(
  parameter int N_CH  = 72,
  parameter int CNT_W = 16,
  parameter int CH_W  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             free_i,
  input  logic             rd_req_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  input  logic [CNT_W-1:0] ram_rdata_i,
  output logic             gnt_o,
  output logic             vld_o,
  output logic [CNT_W-1:0] data_o
);
  logic            vld_q;
  logic [CH_W-1:0] ch_q;
  logic            in_range;

  assign gnt_o = rd_req_i && free_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ch_q  <= '0;
    end else begin
      vld_q <= gnt_o;
      if (gnt_o) ch_q <= rd_ch_i;
    end
  end

  assign in_range = ({1'b0, ch_q} < (CH_W+1)'(N_CH));
  assign vld_o    = vld_q;
  assign data_o   = (vld_q && in_range) ? ram_rdata_i : '0;
endmodule

// File: rtl/mux_pulse_counter.sv
module mux_pulse_counter #(
  parameter  int N_CH  = 72,
  parameter  int CNT_W = 16,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  chan_i,
  input  logic             win_i,
  input  logic             clr_i,
  input  logic             rd_req_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic             rd_gnt_o,
  output logic             rd_vld_o,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             busy_o
);
  logic             sw_re, sw_we, free;
  logic [CH_W-1:0]  sw_addr;
  logic [CNT_W-1:0] sw_wdata, ram_rdata;
  logic             ram_re, ram_we;
  logic [CH_W-1:0]  ram_addr;

  mpc_sweep_ctrl #(.N_CH(N_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chan_i      (chan_i),
    .win_i       (win_i),
    .clr_i       (clr_i),
    .ram_rdata_i (ram_rdata),
    .ram_re_o    (sw_re),
    .ram_we_o    (sw_we),
    .ram_addr_o  (sw_addr),
    .ram_wdata_o (sw_wdata),
    .busy_o      (busy_o),
    .free_o      (free)
  );

  mpc_host_port #(.N_CH(N_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .free_i      (free),
    .rd_req_i    (rd_req_i),
    .rd_ch_i     (rd_ch_i),
    .ram_rdata_i (ram_rdata),
    .gnt_o       (rd_gnt_o),
    .vld_o       (rd_vld_o),
    .data_o      (rd_data_o)
  );

  assign ram_re   = sw_re || rd_gnt_o;
  assign ram_we   = sw_we;
  assign ram_addr = rd_gnt_o ? rd_ch_i : sw_addr;

  mpc_ram #(.DEPTH(N_CH), .W(CNT_W), .AW(CH_W)) u_ram (
    .clk_i   (clk_i),
    .re_i    (ram_re),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (sw_wdata),
    .rdata_o (ram_rdata)
  );
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker #(
  parameter int N_CH = 72,
  parameter int CH_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            rd_gnt_o,
  input logic            rd_vld_o,
  input logic            ram_re_i,
  input logic            ram_we_i,
  input logic [CH_W-1:0] ram_addr_i
);
  logic [15:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (busy_o) len_q <= len_q + 16'd1;
    else             len_q <= '0;
  end

  p_sweep_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (len_q == 16'(3 * N_CH)));

  p_rmw_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_i |-> ($past(ram_re_i, 2) && ram_addr_i == $past(ram_addr_i, 2)));

  p_port_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_i && ram_re_i));

  p_gnt_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_gnt_o |-> !busy_o);

  p_vld_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_gnt_o |=> rd_vld_o);

  p_vld_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(rd_gnt_o));
endmodule

bind mux_pulse_counter mpc_checker #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .rd_gnt_o   (rd_gnt_o),
  .rd_vld_o   (rd_vld_o),
  .ram_re_i   (ram_re),
  .ram_we_i   (ram_we),
  .ram_addr_i (ram_addr)
);

// File: tb/mux_pulse_counter_tb_top.sv
module mux_pulse_counter_tb_top;
  localparam int N    = 5;
  localparam int W    = 3;
  localparam int CW   = 3;
  localparam int MASK = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  chan = '0;
  logic          win = 1'b0, clr = 1'b0, rd_req = 1'b0;
  logic [CW-1:0] rd_ch = '0;
  logic          rd_gnt, rd_vld, busy;
  logic [W-1:0]  rd_data;

  int n_run = 0, n_fail = 0;
  int exp_q [N];

  always #10 clk = ~clk;

  mux_pulse_counter #(.N_CH(N), .CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chan_i(chan), .win_i(win), .clr_i(clr),
    .rd_req_i(rd_req), .rd_ch_i(rd_ch), .rd_gnt_o(rd_gnt), .rd_vld_o(rd_vld),
    .rd_data_o(rd_data), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wait_idle(output int len);
    len = 0;
    while (busy && len < 10000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic read_ch(input int c, input int expv, input string req);
    @(negedge clk);
    rd_req = 1'b1;
    rd_ch  = CW'(c);
    #1;
    chk(rd_gnt == 1'b1, {req, " grant"}, int'(rd_gnt), 1);
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_vld == 1'b1 && int'(rd_data) == expv, req, int'(rd_data), expv);
  endtask

  task automatic read_all(input string req);
    for (int c = 0; c < N; c++) read_ch(c, exp_q[c], req);
  endtask

  // strobe one window with pattern pat, scramble inputs afterwards (R2 snapshot)
  task automatic window(input logic [N-1:0] pat, input string req);
    int len;
    @(negedge clk);
    chan = pat;
    win  = 1'b1;
    @(negedge clk);
    win  = 1'b0;
    chan = ~pat;
    wait_idle(len);
    chk(len == 3 * N, "R4 sweep length", len, 3 * N);
    for (int c = 0; c < N; c++) exp_q[c] = (exp_q[c] + int'(pat[c])) & MASK;
    read_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int len;
    for (int c = 0; c < N; c++) exp_q[c] = 0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R1 clear after reset", int'(busy), 1);
    wait_idle(len);
    read_all("R1 zero after reset");
    for (int c = N; c < (1 << CW); c++) read_ch(c, 0, "R7 out of range");

    // every pattern: repeated highs and multiple wraps (R2, R3, R8)
    for (int p = 0; p < (1 << N); p++) window(N'(p), "R2 R3 R8 count");
    for (int k = 0; k < 9; k++) window('1, "R8 consecutive highs");
    chk(exp_q[0] == 1, "R3 wrap", exp_q[0], 1);

    // R5: strobe during sweep ignored; R9: no grant while busy
    @(negedge clk);
    chan = '0;
    win  = 1'b1;
    @(negedge clk);
    win  = 1'b0;
    repeat (3) @(negedge clk);
    chan   = '1;
    win    = 1'b1;
    rd_req = 1'b1;
    #1;
    chk(rd_gnt == 1'b0, "R9 grant while busy", int'(rd_gnt), 0);
    @(negedge clk);
    win    = 1'b0;
    rd_req = 1'b0;
    len = 4;
    while (busy) begin len++; @(negedge clk); end
    chk(len == 3 * N, "R5 sweep not extended", len, 3 * N);
    read_all("R5 late strobe ignored");

    // R6: clear held during a counting sweep
    @(negedge clk);
    chan = '1;
    win  = 1'b1;
    @(negedge clk);
    win = 1'b0;
    repeat (2) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    wait_idle(len);
    @(negedge clk);
    chk(busy == 1'b1, "R6 deferred clear runs", int'(busy), 1);
    wait_idle(len);
    chk(len == 3 * N, "R6 clear sweep length", len, 3 * N);
    for (int c = 0; c < N; c++) exp_q[c] = 0;
    read_all("R6 deferred clear");

    // R6: clear beats strobe in the same idle cycle
    window('1, "R2 before clear");
    @(negedge clk);
    chan = '1;
    win  = 1'b1;
    clr  = 1'b1;
    @(negedge clk);
    win = 1'b0;
    clr = 1'b0;
    wait_idle(len);
    for (int c = 0; c < N; c++) exp_q[c] = 0;
    read_all("R6 clear priority");

    // R7: readback of distinct values
    window(5'b10101, "R7 pattern");
    window(5'b10001, "R7 pattern");
    read_ch(0, 2, "R7 channel 0");
    read_ch(1, 0, "R7 channel 1");
    read_ch(4, 2, "R7 channel 4");
    read_ch(7, 0, "R7 out of range");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule